// File: doc/BRIEF.md
# Programmable Clock Output Divider

This block generates a clock for an external companion device. It divides a 48 MHz internal clock by a programmable ratio of N+1. The ratio N is a 4-bit setting that can be rewritten at any time. After reset, N is 11, so the output runs at 4 MHz.

A new ratio never cuts short a pulse that is already in progress. It is adopted only when the current output period has completed.

While the USB bus is suspended, the block can drop the output to a slow, low-power clock. This slow clock is built from a single-cycle enable tick at twice the slow frequency. The slow frequency is nominally 30 kHz.

- The hand-over to the slow clock happens once suspend has been held for a programmable delay. The default delay is 48000 input cycles, which is 1 ms.
- A configuration bit can pin the output to the divided clock permanently, so that it never falls back.
- When suspend ends, the output returns to the divided clock.
- Every switch between sources is made only while both sources are low, so no runt pulse can reach the output.

Top module: `clkout_divider`

## Requirements
- R1: The output period is N+1 input clock cycles for every accepted N in the range 1 to 11.
- R2: For an odd ratio (N+1 odd), the high phase is one input cycle longer than the low phase. For an even ratio, both phases are equal.
- R3: During reset the output is low. After reset, N is 11, giving a high phase and a low phase of 6 input cycles each, and the lazy-clock disable bit is 0.
- R4: With N = 0, the output follows the input clock.
- R5: A write with a ratio value above 11 leaves the ratio unchanged. The lazy-clock disable bit of the same write is still taken.
- R6: A new N is adopted only at the end of the output period in progress. While changing between ratios with N of 1 or more, no output pulse is shorter than one input cycle.
- R7: With the lazy-clock disable bit at 0, the output stays divided until suspend has been high for SUSP_DLY cycles. After that, the output is the slow clock, which toggles on each slow tick, and no runt pulse occurs during the switch.
- R8: With the lazy-clock disable bit at 1, suspend never changes the output.
- R9: When suspend falls, the output returns to the divided clock. The switch takes place while the slow clock is low, with no runt pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 48 MHz internal clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the ratio and the lazy-clock disable bit |
| cfg_div | input | DIV_W | New ratio value N |
| cfg_nolazy | input | 1 | New lazy-clock disable bit (1 keeps the divided clock during suspend) |
| suspend | input | 1 | USB suspend state, synchronous to clk |
| slow_tick | input | 1 | One-cycle enable that toggles the slow clock |
| clk_out | output | 1 | Clock output |

## Verification
On every cycle, the assertions check the following:
- the period counter stays within the active ratio;
- the active ratio changes only at a period boundary and never exceeds 11;
- the source switch happens only while the slow clock is low;
- the slow clock is entered only after the full suspend delay;
- a pinned configuration never enters the slow clock.

Only the bench scenarios, which time every output edge, can show the actual pulse widths: the duty split of odd ratios, the 48 MHz pass-through, and the absence of short pulses across ratio changes and suspend transitions.

// File: rtl/clkout_divider.sv
`timescale 1ns/1ps
module clkout_divider #(
  parameter int DIV_W    = 4,
  parameter int DIV_RST  = 11,
  parameter int DIV_MAX  = 11,
  parameter int SUSP_DLY = 48000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic             cfg_nolazy,
  input  logic             suspend,
  input  logic             slow_tick,
  output logic             clk_out
);
  localparam int SW = $clog2(SUSP_DLY + 1);
  localparam logic [DIV_W-1:0] RSTV = DIV_RST[DIV_W-1:0];
  localparam logic [DIV_W-1:0] MAXV = DIV_MAX[DIV_W-1:0];
  localparam logic [SW-1:0]    DLYV = SW'(SUSP_DLY);

  logic [DIV_W-1:0] div_reg, cur_n, cnt, cnt_nx, n_nx, pos_nx;
  logic [DIV_W:0]   hi_nx;
  logic             nolazy_q, ph_q, slow_q, lazy_on, bypass, want_lazy;
  logic [SW-1:0]    susp_cnt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      div_reg  <= RSTV;
      nolazy_q <= 1'b0;
    end else if (cfg_we) begin
      nolazy_q <= cfg_nolazy;
      if (cfg_div <= MAXV) div_reg <= cfg_div;
    end

  always_comb begin
    if (cnt == '0) begin
      n_nx   = div_reg;
      cnt_nx = div_reg;
    end else begin
      n_nx   = cur_n;
      cnt_nx = cnt - 1'b1;
    end
    pos_nx = n_nx - cnt_nx;
    hi_nx  = ({1'b0, n_nx} + (DIV_W+1)'(2)) >> 1;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt   <= '0;
      cur_n <= RSTV;
      ph_q  <= 1'b0;
    end else begin
      cnt   <= cnt_nx;
      cur_n <= n_nx;
      ph_q  <= {1'b0, pos_nx} < hi_nx;
    end

  assign bypass = (cur_n == '0);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)         slow_q <= 1'b0;
    else if (slow_tick) slow_q <= ~slow_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                     susp_cnt <= '0;
    else if (!suspend || nolazy_q)  susp_cnt <= '0;
    else if (susp_cnt != DLYV)      susp_cnt <= susp_cnt + 1'b1;

  assign want_lazy = (susp_cnt == DLYV);

  always_ff @(negedge clk or negedge rst_n)
    if (!rst_n) lazy_on <= 1'b0;
    else if (lazy_on != want_lazy && !slow_q && (bypass || !ph_q))
      lazy_on <= want_lazy;

  assign clk_out = lazy_on ? slow_q : (bypass ? clk : ph_q);
endmodule

module clkout_divider_chk #(
  parameter int DIV_W    = 4,
  parameter int DIV_MAX  = 11,
  parameter int SUSP_DLY = 48000,
  parameter int SW       = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [DIV_W-1:0] cnt,
  input logic [DIV_W-1:0] cur_n,
  input logic             lazy_on,
  input logic             slow_q,
  input logic [SW-1:0]    susp_cnt,
  input logic             nolazy_q
);
  // R1
  cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= cur_n);
  // R6
  ratio_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cur_n) |-> $past(cnt) == '0);
  // R5
  ratio_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cur_n <= DIV_MAX);
  // R9
  switch_when_slow_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(lazy_on) |-> !slow_q);
  // R7
  lazy_after_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lazy_on) |-> susp_cnt == SW'(SUSP_DLY));
  // R8
  pinned_stays_divided_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nolazy_q && !lazy_on) |=> !lazy_on);
endmodule

bind clkout_divider clkout_divider_chk #(
  .DIV_W(DIV_W), .DIV_MAX(DIV_MAX), .SUSP_DLY(SUSP_DLY), .SW(SW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt(cnt), .cur_n(cur_n), .lazy_on(lazy_on),
  .slow_q(slow_q), .susp_cnt(susp_cnt), .nolazy_q(nolazy_q)
);

// File: tb/clkout_divider_test.sv
`timescale 1ns/1ps
module clkout_divider_test;
  logic clk = 1'b0, rst_n = 1'b0, cfg_we = 1'b0, cfg_nolazy = 1'b0;
  logic suspend = 1'b0, slow_tick = 1'b0;
  logic [3:0] cfg_div = 4'd0;
  logic clk_out;
  int total = 0, bad = 0;
  bit done = 0;
  realtime t_r = 0, t_f = 0, hi_w = 0, lo_w = 0, min_w = 1e9;

  always #2.5 clk = ~clk;

  clkout_divider #(.SUSP_DLY(200)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_div(cfg_div),
    .cfg_nolazy(cfg_nolazy), .suspend(suspend), .slow_tick(slow_tick),
    .clk_out(clk_out));

  always @(posedge clk_out) begin
    lo_w = $realtime - t_f; t_r = $realtime;
    if (lo_w < min_w) min_w = lo_w;
  end
  always @(negedge clk_out) begin
    hi_w = $realtime - t_r; t_f = $realtime;
    if (hi_w < min_w) min_w = hi_w;
  end

  initial begin
    forever begin
      repeat (39) @(negedge clk);
      slow_tick = 1'b1;
      @(negedge clk);
      slow_tick = 1'b0;
    end
  end

  task automatic chk(input bit ok, input string tag, input real act, input real exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0.2f expected=%0.2f", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic write_cfg(input logic [3:0] d, input logic nl);
    @(negedge clk);
    cfg_we = 1'b1; cfg_div = d; cfg_nolazy = nl;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic measure(input string tag, input real eh, input real el);
    repeat (3) @(posedge clk_out);
    @(negedge clk_out);
    #0.1;
    chk(hi_w > eh - 0.01 && hi_w < eh + 0.01, {tag, " high"}, hi_w, eh);
    chk(lo_w > el - 0.01 && lo_w < el + 0.01, {tag, " low"}, lo_w, el);
  endtask

  task automatic test_reset;
    cyc(4);
    chk(clk_out == 1'b0, "R3 output low in reset", clk_out, 0);
    @(negedge clk) rst_n = 1'b1;
    measure("R3/R1 default N=11", 30.0, 30.0);
  endtask

  task automatic test_ratios;
    write_cfg(4'd5, 1'b0);  measure("R1 N=5", 15.0, 15.0);
    write_cfg(4'd2, 1'b0);  measure("R2 N=2 odd", 10.0, 5.0);
    write_cfg(4'd4, 1'b0);  measure("R2 N=4 odd", 15.0, 10.0);
    write_cfg(4'd7, 1'b0);  measure("R2 N=7 even", 20.0, 20.0);
    write_cfg(4'd0, 1'b0);  measure("R4 N=0 pass", 2.5, 2.5);
  endtask

  task automatic test_clamp;
    write_cfg(4'd3, 1'b0);   measure("R5 N=3", 10.0, 10.0);
    write_cfg(4'd13, 1'b0);  measure("R5 N=13 ignored", 10.0, 10.0);
    write_cfg(4'd15, 1'b1);  measure("R5 N=15 ignored", 10.0, 10.0);
    write_cfg(4'd3, 1'b0);
  endtask

  task automatic test_change;
    write_cfg(4'd11, 1'b0);
    measure("R6 setup N=11", 30.0, 30.0);
    min_w = 1e9;
    @(posedge clk_out);
    cyc(1);
    write_cfg(4'd1, 1'b0);
    @(negedge clk_out); #0.1;
    chk(hi_w > 29.99 && hi_w < 30.01, "R6 old high kept", hi_w, 30.0);
    @(posedge clk_out); #0.1;
    chk(lo_w > 29.99 && lo_w < 30.01, "R6 old low kept", lo_w, 30.0);
    measure("R6 new N=1", 5.0, 5.0);
    write_cfg(4'd6, 1'b0);
    measure("R6 back N=6", 20.0, 15.0);
    chk(min_w > 4.99, "R6 no runt pulse", min_w, 5.0);
  endtask

  task automatic test_lazy;
    write_cfg(4'd3, 1'b0);
    measure("R7 setup", 10.0, 10.0);
    min_w = 1e9;
    @(negedge clk) suspend = 1'b1;
    cyc(120);
    measure("R7 before delay", 10.0, 10.0);
    cyc(300);
    measure("R7 slow clock", 200.0, 200.0);
    chk(min_w > 9.99, "R7 no runt on entry", min_w, 10.0);
    min_w = 1e9;
    @(negedge clk) suspend = 1'b0;
    cyc(200);
    measure("R9 divided again", 10.0, 10.0);
    chk(min_w > 9.99, "R9 no runt on exit", min_w, 10.0);
  endtask

  task automatic test_pinned;
    write_cfg(4'd3, 1'b1);
    @(negedge clk) suspend = 1'b1;
    cyc(600);
    measure("R8 pinned in suspend", 10.0, 10.0);
    @(negedge clk) suspend = 1'b0;
    write_cfg(4'd3, 1'b0);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    test_reset();
    test_ratios();
    test_clamp();
    test_change();
    test_lazy();
    test_pinned();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule